// File: doc/BRIEF.md
# Two-Client ZBT SRAM Arbiter

This block lets two client modules take turns on a single zero-bus-turnaround synchronous SRAM port. A client raises its request, waits for its grant, and then presents one command per cycle for as long as it keeps the request high. A command is a write when its write enable is high and a read otherwise. The arbiter passes the owner's address, data and write enable straight to the memory port. On every other cycle the memory sees an idle cycle with its enable low.

Read data comes back on a fixed four-cycle pipeline. A small tag pipeline sends each returned word to the client that issued the read, with a valid strobe, even when the grant has since moved to the other client. Ties go to a rotating priority pointer. A waiting client cannot be starved: after a configurable number of cycles of contention, the arbiter withdraws the current grant. The withdrawn client must then lower its request. Nobody is granted until it has done so.

Top module: `zbt_share_arb`

## Requirements
- R1: After reset, both grants, both read valids and the SRAM enable are low, and the priority pointer favours client 0.
- R2: At most one grant is high in any cycle. When the SRAM is free, a requesting client is granted in the cycle after its request is seen.
- R3: When both clients request on the same cycle and no grant is held, the client named by the priority pointer wins. The pointer starts at client 0 and moves to the other client whenever an owner loses its grant.
- R4: An owner keeps its grant for as long as its request stays high and the other client is not waiting. Its grant goes low in the cycle after it lowers its request.
- R5: If the other client requests during every cycle of MAX_WAIT (default 64) consecutive owned cycles, the owner's grant goes low in the next cycle.
- R6: After a withdrawal, no grant is given while the withdrawn client still requests. In the cycle after it lowers its request, the waiting client is granted.
- R7: The SRAM enable is high only in cycles where a client holds both its grant and its request. The port then carries that client's address, write data and write enable (1 = write, 0 = read). A command presented without a grant reaches neither the port nor the memory contents.
- R8: A read presented in cycle c raises rvalid_o of the issuing client in cycle c+4, with the stored word on that client's rdata_o. This holds even if ownership changed in between. A client's rdata_o is zero while its rvalid_o is low.
- R9: Reads and writes from the owner go out on adjacent cycles in any order with no idle cycles. A read that follows a write to the same address returns the new data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 2 | Per-client request |
| gnt_o | output | 2 | Per-client grant |
| addr_i | input | 2×AW | Per-client address |
| wdata_i | input | 2×DW | Per-client write data |
| we_i | input | 2 | Per-client write enable (1 write, 0 read) |
| rvalid_o | output | 2 | Per-client read return strobe |
| rdata_o | output | 2×DW | Per-client read return data |
| sram_en_o | output | 1 | SRAM command enable (active high) |
| sram_we_o | output | 1 | SRAM write enable |
| sram_addr_o | output | AW | SRAM address |
| sram_wdata_o | output | DW | SRAM write data |
| sram_rdata_i | input | DW | SRAM read data, valid four cycles after the read |

## Verification
Grant changes are due one clock edge after the request pattern that causes them, so the bench checks gnt_o in the cycle following each drive. The one exception is withdrawal, which is checked on the exact cycle MAX_WAIT cycles after contention began. The SRAM port is combinational from the owner's inputs and is sampled in the same cycle, one time step after the inputs settle. Every read is logged with its issue cycle and the value a shadow memory holds at that moment. Both clients' rvalid_o and rdata_o are then compared exactly four cycles later, and every cycle without a due read must show rvalid_o low.

// File: rtl/zbt_arb_pkg.sv
package zbt_arb_pkg;
  localparam int unsigned N_CLI = 2;

  typedef logic cid_t;

  typedef struct packed {
    logic vld;
    cid_t id;
  } rd_tag_t;
endpackage

// File: rtl/zbt_arb_ctrl.sv
module zbt_arb_ctrl
  import zbt_arb_pkg::*;
#(
  parameter int unsigned MAX_WAIT = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CLI-1:0] req_i,
  output logic [N_CLI-1:0] gnt_o
);
  localparam int unsigned WAIT_W = $clog2(MAX_WAIT + 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(MAX_WAIT - 1);

  logic [N_CLI-1:0]  gnt_q, gnt_d;
  cid_t              prio_q, prio_d;
  logic              drain_q, drain_d;
  cid_t              drain_id_q, drain_id_d;
  logic [WAIT_W-1:0] wait_q, wait_d;

  logic busy;
  cid_t own;

  assign busy = |gnt_q;
  assign own  = gnt_q[1];

  always_comb begin
    gnt_d      = gnt_q;
    prio_d     = prio_q;
    drain_d    = drain_q;
    drain_id_d = drain_id_q;
    wait_d     = wait_q;
    if (busy) begin
      if (!req_i[own]) begin
        gnt_d  = '0;
        prio_d = ~own;
        wait_d = '0;
      end else if (req_i[~own]) begin
        if (wait_q == WAIT_LAST) begin
          // withdraw: hold everyone off until the owner lets go
          gnt_d      = '0;
          drain_d    = 1'b1;
          drain_id_d = own;
          prio_d     = ~own;
          wait_d     = '0;
        end else begin
          wait_d = wait_q + 1'b1;
        end
      end else begin
        wait_d = '0;
      end
    end else begin
      wait_d = '0;
      if (!(drain_q && req_i[drain_id_q])) begin
        drain_d = 1'b0;
        if (&req_i) gnt_d = prio_q ? 2'b10 : 2'b01;
        else        gnt_d = req_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q      <= '0;
      prio_q     <= 1'b0;
      drain_q    <= 1'b0;
      drain_id_q <= 1'b0;
      wait_q     <= '0;
    end else begin
      gnt_q      <= gnt_d;
      prio_q     <= prio_d;
      drain_q    <= drain_d;
      drain_id_q <= drain_id_d;
      wait_q     <= wait_d;
    end
  end

  assign gnt_o = gnt_q;
endmodule

// File: rtl/zbt_cmd_mux.sv
module zbt_cmd_mux
  import zbt_arb_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic [N_CLI-1:0]         gnt_i,
  input  logic [N_CLI-1:0]         req_i,
  input  logic [N_CLI-1:0][AW-1:0] addr_i,
  input  logic [N_CLI-1:0][DW-1:0] wdata_i,
  input  logic [N_CLI-1:0]         we_i,
  output logic                     sram_en_o,
  output logic                     sram_we_o,
  output logic [AW-1:0]            sram_addr_o,
  output logic [DW-1:0]            sram_wdata_o,
  output rd_tag_t                  issue_o
);
  cid_t sel;

  always_comb begin
    sram_en_o    = 1'b0;
    sram_we_o    = 1'b0;
    sram_addr_o  = '0;
    sram_wdata_o = '0;
    sel          = 1'b0;
    for (int i = 0; i < int'(N_CLI); i++) begin
      if (gnt_i[i] && req_i[i]) begin
        sram_en_o    = 1'b1;
        sram_we_o    = we_i[i];
        sram_addr_o  = addr_i[i];
        sram_wdata_o = wdata_i[i];
        sel          = (i == 1);
      end
    end
  end

  assign issue_o.vld = sram_en_o & ~sram_we_o;
  assign issue_o.id  = sel;
endmodule

// File: rtl/zbt_rd_track.sv
module zbt_rd_track
  import zbt_arb_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned RD_LAT = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  rd_tag_t                  issue_i,
  input  logic [DW-1:0]            sram_rdata_i,
  output logic [N_CLI-1:0]         rvalid_o,
  output logic [N_CLI-1:0][DW-1:0] rdata_o
);
  localparam int unsigned LAST = RD_LAT - 1;

  rd_tag_t pipe_q [RD_LAT];

  for (genvar s = 0; s < int'(RD_LAT); s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pipe_q[s] <= '0;
      else if (s == 0) pipe_q[s] <= issue_i;
      else             pipe_q[s] <= pipe_q[(s == 0) ? 0 : s - 1];
    end
  end

  for (genvar c = 0; c < int'(N_CLI); c++) begin : g_cli
    assign rvalid_o[c] = pipe_q[LAST].vld && (pipe_q[LAST].id == 1'(c));
    assign rdata_o[c]  = rvalid_o[c] ? sram_rdata_i : '0;
  end
endmodule

// File: rtl/zbt_share_arb.sv
module zbt_share_arb
  import zbt_arb_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned DW       = 32,
  parameter int unsigned RD_LAT   = 4,
  parameter int unsigned MAX_WAIT = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_CLI-1:0]         req_i,
  output logic [N_CLI-1:0]         gnt_o,
  input  logic [N_CLI-1:0][AW-1:0] addr_i,
  input  logic [N_CLI-1:0][DW-1:0] wdata_i,
  input  logic [N_CLI-1:0]         we_i,
  output logic [N_CLI-1:0]         rvalid_o,
  output logic [N_CLI-1:0][DW-1:0] rdata_o,
  output logic                     sram_en_o,
  output logic                     sram_we_o,
  output logic [AW-1:0]            sram_addr_o,
  output logic [DW-1:0]            sram_wdata_o,
  input  logic [DW-1:0]            sram_rdata_i
);
  rd_tag_t issue;

  zbt_arb_ctrl #(.MAX_WAIT(MAX_WAIT)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .gnt_o  (gnt_o)
  );

  zbt_cmd_mux #(.AW(AW), .DW(DW)) u_mux (
    .gnt_i        (gnt_o),
    .req_i        (req_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .we_i         (we_i),
    .sram_en_o    (sram_en_o),
    .sram_we_o    (sram_we_o),
    .sram_addr_o  (sram_addr_o),
    .sram_wdata_o (sram_wdata_o),
    .issue_o      (issue)
  );

  zbt_rd_track #(.DW(DW), .RD_LAT(RD_LAT)) u_rd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .issue_i      (issue),
    .sram_rdata_i (sram_rdata_i),
    .rvalid_o     (rvalid_o),
    .rdata_o      (rdata_o)
  );
endmodule

// File: rtl/zbt_share_arb_chk.sv
module zbt_share_arb_chk #(
  parameter int unsigned RD_LAT = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] req_i,
  input logic [1:0] gnt_o,
  input logic [1:0] rvalid_o,
  input logic       sram_en_o,
  input logic       sram_we_o
);
  assert_one_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  assert_idle_port_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == 2'b00) |-> !sram_en_o);

  for (genvar i = 0; i < 2; i++) begin : g_cli
    assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_o[i] && req_i[i] && !req_i[1-i]) |=> gnt_o[i]);

    assert_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_o[i] && !req_i[i]) |=> !gnt_o[i]);

    assert_drain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(gnt_o[i]) && $past(req_i[i]) && req_i[i]) |=> (gnt_o == 2'b00));
  end

  if (RD_LAT == 4) begin : g_lat4
    assert_return_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sram_en_o && !sram_we_o) |-> ##4 (rvalid_o != 2'b00));

    assert_no_spurious_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rvalid_o != 2'b00) |-> $past(sram_en_o && !sram_we_o, 4));
  end
endmodule

bind zbt_share_arb zbt_share_arb_chk #(.RD_LAT(RD_LAT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .gnt_o     (gnt_o),
  .rvalid_o  (rvalid_o),
  .sram_en_o (sram_en_o),
  .sram_we_o (sram_we_o)
);

// File: tb/sim_zbt_share_arb.sv
`timescale 1ns/1ps
module sim_zbt_share_arb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]        req_d, we_d, gnt_o, rvalid_o;
  logic [1:0][15:0]  addr_d;
  logic [1:0][31:0]  wd_d, rdata_o;
  logic              sram_en, sram_we;
  logic [15:0]       sram_addr;
  logic [31:0]       sram_wdata, sram_rdata;

  zbt_share_arb u0 (
    .clk_i (clk), .rst_ni (rst_ni),
    .req_i (req_d), .gnt_o (gnt_o), .addr_i (addr_d), .wdata_i (wd_d), .we_i (we_d),
    .rvalid_o (rvalid_o), .rdata_o (rdata_o),
    .sram_en_o (sram_en), .sram_we_o (sram_we), .sram_addr_o (sram_addr),
    .sram_wdata_o (sram_wdata), .sram_rdata_i (sram_rdata)
  );

  // behavioural ZBT model: data on the bus four cycles after the read
  logic [31:0] mem [16];
  logic [31:0] rp  [4];
  always @(posedge clk) begin
    if (sram_en && sram_we) mem[sram_addr[3:0]] <= sram_wdata;
    rp[0] <= (sram_en && !sram_we) ? mem[sram_addr[3:0]] : 32'h0;
    rp[1] <= rp[0];
    rp[2] <= rp[1];
    rp[3] <= rp[2];
  end
  assign sram_rdata = rp[3];

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  logic [31:0] shadow [16];
  logic [1:0]  exp_v [8];
  logic [31:0] exp_d [8];

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  task automatic set(input int i, input bit rq, input bit we, input int a, input logic [31:0] d);
    req_d[i]  = rq;
    we_d[i]   = we;
    addr_d[i] = 16'(a & 15);
    wd_d[i]   = d;
  endtask

  // record issued commands, advance one cycle, check due read returns (R8, R9)
  task automatic tick();
    for (int i = 0; i < 2; i++) begin
      if (gnt_o[i] && req_d[i]) begin
        if (we_d[i]) shadow[addr_d[i][3:0]] = wd_d[i];
        else begin
          exp_v[(cyc + 4) % 8][i] = 1'b1;
          exp_d[(cyc + 4) % 8]    = shadow[addr_d[i][3:0]];
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
    for (int i = 0; i < 2; i++) begin
      chk(rvalid_o[i] == exp_v[cyc % 8][i], "R8 rvalid", 32'(rvalid_o[i]), 32'(exp_v[cyc % 8][i]));
      if (exp_v[cyc % 8][i])
        chk(rdata_o[i] == exp_d[cyc % 8], "R8 R9 rdata", rdata_o[i], exp_d[cyc % 8]);
      else
        chk(rdata_o[i] == 32'h0, "R8 rdata idle", rdata_o[i], 32'h0);
    end
    exp_v[cyc % 8] = 2'b00;
    chk($countones(gnt_o) <= 1, "R2 one grant", 32'(gnt_o), 32'h1);
  endtask

  logic [1:0] pg, rv;

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < 16; k++) begin mem[k] = '0; shadow[k] = '0; end
    for (int k = 0; k < 8; k++) begin exp_v[k] = '0; exp_d[k] = '0; end
    req_d = '0; we_d = '0; addr_d = '0; wd_d = '0;
    repeat (6) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk(gnt_o == 2'b00 && rvalid_o == 2'b00 && !sram_en, "R1 reset", {gnt_o, rvalid_o, 1'b0, sram_en}, 32'h0);

    // tie after reset: client 0 wins one cycle later
    set(0, 1, 0, 0, 0); set(1, 1, 1, 3, 32'hDEAD0001);
    #1 chk(!sram_en, "R7 no grant yet", 32'(sram_en), 32'h0);
    tick();
    chk(gnt_o == 2'b01, "R3 tie reset priority", 32'(gnt_o), 32'h1);

    // back-to-back mix; client 1 keeps presenting ungranted writes
    set(0, 1, 1, 3, 32'hA5A5_0003);
    #1 chk(sram_en && sram_we && sram_addr == 16'd3 && sram_wdata == 32'hA5A5_0003,
           "R7 port carries owner", sram_wdata, 32'hA5A5_0003);
    tick();
    set(0, 1, 0, 3, 0);            tick();
    set(0, 1, 1, 3, 32'h0B0B_0003); tick();
    set(0, 1, 0, 3, 0);            tick();
    set(0, 1, 1, 5, 32'h0C0C_0005); tick();
    set(0, 1, 0, 5, 0);            tick();

    // read then release: return steered to client 0 after hand-over
    set(1, 1, 0, 5, 0);
    set(0, 1, 0, 3, 0); tick();
    set(0, 0, 0, 0, 0); tick();
    chk(gnt_o == 2'b00, "R4 release next cycle", 32'(gnt_o), 32'h0);
    tick();
    chk(gnt_o == 2'b10, "R2 waiting client granted", 32'(gnt_o), 32'h2);

    // sole owner keeps grant
    for (int k = 0; k < 10; k++) begin
      set(1, 1, k[0], k, 32'h1000 + 32'(k));
      tick();
      chk(gnt_o == 2'b10, "R4 hold", 32'(gnt_o), 32'h2);
    end

    // rotation: owner 0 releases, then a tie goes to client 1
    set(1, 0, 0, 0, 0); tick();
    chk(gnt_o == 2'b00, "R4 release", 32'(gnt_o), 32'h0);
    set(0, 1, 0, 3, 0); tick();
    chk(gnt_o == 2'b01, "R2 free grant", 32'(gnt_o), 32'h1);
    set(0, 0, 0, 0, 0); tick();
    set(0, 1, 0, 5, 0); set(1, 1, 0, 3, 0); tick();
    chk(gnt_o == 2'b10, "R3 rotated priority", 32'(gnt_o), 32'h2);

    // withdrawal after 64 contended cycles
    for (int k = 0; k < 63; k++) tick();
    chk(gnt_o == 2'b10, "R5 still owned at limit", 32'(gnt_o), 32'h2);
    tick();
    chk(gnt_o == 2'b00, "R5 withdrawn", 32'(gnt_o), 32'h0);
    set(1, 1, 1, 7, 32'hBAD0_0007);
    #1 chk(!sram_en, "R7 withdrawn owner ignored", 32'(sram_en), 32'h0);
    tick();
    chk(gnt_o == 2'b00, "R6 no grant while draining", 32'(gnt_o), 32'h0);
    set(1, 0, 0, 0, 0); tick();
    chk(gnt_o == 2'b01, "R6 grant after drain", 32'(gnt_o), 32'h1);
    set(0, 1, 0, 7, 0); tick();
    set(0, 0, 0, 0, 0); tick();

    // constrained random traffic
    pg = gnt_o; rv = '0;
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < 2; i++) begin
        if (req_d[i]) begin
          if (!gnt_o[i] && pg[i]) rv[i] = 1'b1;
          if (rv[i]) begin
            if ($urandom % 2 == 0) req_d[i] = 1'b0;
          end else if (gnt_o[i] && ($urandom % 40 == 0)) req_d[i] = 1'b0;
        end else if ($urandom % 4 == 0) req_d[i] = 1'b1;
        if (!req_d[i]) rv[i] = 1'b0;
        we_d[i]   = 1'($urandom % 2);
        addr_d[i] = 16'($urandom % 16);
        wd_d[i]   = $urandom;
      end
      pg = gnt_o;
      tick();
    end
    req_d = '0;
    repeat (8) tick();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule